// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a memory-mapped watchdog with a 32-bit write port and a combinational read port. Software sets a reload value and a clock divider, enables the watchdog, and must then keep writing one exact service word before a down-counter runs out. Each counter step is driven by a divided peripheral clock. When the count expires, a sticky status flag is set. An interrupt level and a reset pulse of programmable length can be enabled.

Both configuration registers are guarded by a 12-bit key carried in bits [23:12] of each write. A write with the wrong key is dropped. The service register reacts only to its magic word. The reload field is scaled by a power of two, set by the parameter `CNT_SHIFT` (default 12, so the factor is 0x1000). This lets a small field cover long intervals.

Top module: `wdg_timer`

## Requirements
- R1: After reset, the mode register reads 0x0, the counter control register reads 0x00003FFC (reload field 0xFFF, divider select 0), the status register reads 0, and both `wdt_irq` and `wdt_rst` are low.
- R2: A write to offset 0x0 (mode) is taken only when bits [23:12] equal 0xABC; otherwise the register keeps its value. Bit 0 is enable, bit 1 is reset-output enable, bit 2 is interrupt enable, and bits [5:4] are the pulse-length code. A read returns these fields with all other bits zero.
- R3: A write to offset 0x4 (counter control) is taken only when bits [23:12] equal 0x920. Bits [13:2] hold the reload field and bits [1:0] the divider select. A read returns bits [13:0] with all other bits zero.
- R4: The divider select values 0, 1, 2 and 3 divide the clock by 8, 64, 512 and 4096. The status flag rises exactly field × 2^CNT_SHIFT × divisor cycles after the clock edge that reloads the counter.
- R5: Writing exactly 0x00001999 to offset 0x8 reloads the counter, restarts the divider and clears the status flag. Any other value written there has no effect.
- R6: On expiry, status bit 0 (offset 0xC) is set and stays set until the next reload. The counter then rests at zero and raises no further expiry.
- R7: If the reset output is enabled, `wdt_rst` goes high in the cycle after the expiry edge and stays high for 2^(code+1) cycles: 2, 4, 8 or 16 for codes 0 to 3. It fires once per expiry.
- R8: `wdt_irq` is high exactly while the status flag is set and the interrupt enable is set.
- R9: While the enable bit is clear, the counter does not advance and no expiry occurs.
- R10: A keyed mode write that sets enable from 0 to 1 reloads the counter and clears the status flag, just as a service write does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | ADDR_W | Byte offset used for writes and reads |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` (combinational) |
| wdt_irq | output | 1 | Interrupt level |
| wdt_rst | output | 1 | Reset pulse |

## Verification
The assertions assume that `wr_en` is a known single-cycle strobe and that `addr` is word-aligned. The bench drives every write for exactly one cycle at an aligned offset, including the random ones. The bench uses a reload field of at least 1, because a zero field never expires. It also leaves at least one full interval between a reload and any check of the pulse, so a pulse never overlaps the next reload. Random keyed and unkeyed writes mix the random field values with wrong keys that are forced to differ from the right one.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int unsigned PRE_W = 13;

    localparam logic [11:0] MODE_KEY    = 12'hABC;
    localparam logic [11:0] CTRL_KEY    = 12'h920;
    localparam logic [31:0] SERVICE_VAL = 32'h0000_1999;

    typedef enum logic [1:0] {
        REG_MODE    = 2'd0,
        REG_CTRL    = 2'd1,
        REG_SERVICE = 2'd2,
        REG_STATUS  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [1:0] len_code;
        logic       irq_en;
        logic       rst_en;
        logic       en;
    } mode_t;

    typedef struct packed {
        logic [11:0] reload;
        logic [1:0]  div_sel;
    } ctrl_t;

    function automatic logic [PRE_W-1:0] div_terminal(input logic [1:0] sel);
        logic [PRE_W-1:0] one;
        one = {{(PRE_W-1){1'b0}}, 1'b1};
        return (one << (3 + 3 * int'(sel))) - one;
    endfunction

    function automatic logic [4:0] pulse_cycles(input logic [1:0] code);
        return 5'd2 << code;
    endfunction

endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
    import wdg_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wr_data,
    output mode_t             mode_q,
    output ctrl_t             ctrl_q,
    output logic              service_evt,
    output logic              enable_rise
);

    reg_sel_e sel;
    logic     mode_ok;
    logic     ctrl_ok;
    mode_t    mode_new;

    assign sel      = reg_sel_e'(addr[3:2]);
    assign mode_ok  = wr_en && (sel == REG_MODE) && (wr_data[23:12] == MODE_KEY);
    assign ctrl_ok  = wr_en && (sel == REG_CTRL) && (wr_data[23:12] == CTRL_KEY);
    assign mode_new = '{len_code: wr_data[5:4], irq_en: wr_data[2],
                        rst_en: wr_data[1], en: wr_data[0]};

    assign service_evt = wr_en && (sel == REG_SERVICE) && (wr_data == SERVICE_VAL);
    assign enable_rise = mode_ok && mode_new.en && !mode_q.en;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            ctrl_q <= '{reload: 12'hFFF, div_sel: 2'd0};
        end else begin
            if (mode_ok) mode_q <= mode_new;
            if (ctrl_ok) ctrl_q <= '{reload: wr_data[13:2], div_sel: wr_data[1:0]};
        end
    end

endmodule

// File: rtl/wdg_prescale.sv
module wdg_prescale
    import wdg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       clear,
    input  logic [1:0] div_sel,
    output logic       tick
);

    logic [PRE_W-1:0] pre_q;

    assign tick = run && (pre_q == div_terminal(div_sel));

    always_ff @(posedge clk) begin
        if (rst || clear || !run || tick) pre_q <= '0;
        else                              pre_q <= pre_q + 1'b1;
    end

endmodule

// File: rtl/wdg_down.sv
module wdg_down #(
    parameter int unsigned FIELD_W   = 12,
    parameter int unsigned CNT_SHIFT = 12,
    localparam int unsigned CNT_W    = FIELD_W + CNT_SHIFT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               tick,
    input  logic               reload,
    input  logic [FIELD_W-1:0] field,
    output logic [CNT_W-1:0]   cnt_q,
    output logic               expire,
    output logic               sts_q
);

    logic [CNT_W-1:0] load_val;
    logic             at_one;

    assign load_val = {field, {CNT_SHIFT{1'b0}}};
    assign at_one   = (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1});
    assign expire   = run && tick && at_one && !reload;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= load_val;
            sts_q <= 1'b0;
        end else if (reload) begin
            cnt_q <= load_val;
            sts_q <= 1'b0;
        end else begin
            if (run && tick && (cnt_q != '0)) cnt_q <= cnt_q - 1'b1;
            if (expire) sts_q <= 1'b1;
        end
    end

endmodule

// File: rtl/wdg_pulse.sv
module wdg_pulse
    import wdg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fire,
    input  logic       allow,
    input  logic [1:0] len_code,
    output logic       pulse
);

    logic [4:0] left_q;

    assign pulse = (left_q != '0);

    always_ff @(posedge clk) begin
        if (rst)                left_q <= '0;
        else if (fire && allow) left_q <= pulse_cycles(len_code);
        else if (pulse)         left_q <= left_q - 1'b1;
    end

endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
    import wdg_pkg::*;
#(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned FIELD_W   = 12,
    parameter int unsigned CNT_SHIFT = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    output logic              wdt_irq,
    output logic              wdt_rst
);

    localparam int unsigned CNT_W = FIELD_W + CNT_SHIFT;

    mode_t            mode_q;
    ctrl_t            ctrl_q;
    logic             service_evt;
    logic             enable_rise;
    logic             reload_evt;
    logic             tick;
    logic             expire;
    logic             sts_q;
    logic [CNT_W-1:0] cnt_q;

    assign reload_evt = service_evt || enable_rise;

    wdg_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .mode_q(mode_q), .ctrl_q(ctrl_q),
        .service_evt(service_evt), .enable_rise(enable_rise)
    );

    wdg_prescale u_pre (
        .clk(clk), .rst(rst), .run(mode_q.en), .clear(reload_evt),
        .div_sel(ctrl_q.div_sel), .tick(tick)
    );

    wdg_down #(.FIELD_W(FIELD_W), .CNT_SHIFT(CNT_SHIFT)) u_down (
        .clk(clk), .rst(rst), .run(mode_q.en), .tick(tick), .reload(reload_evt),
        .field(ctrl_q.reload), .cnt_q(cnt_q), .expire(expire), .sts_q(sts_q)
    );

    wdg_pulse u_pulse (
        .clk(clk), .rst(rst), .fire(expire), .allow(mode_q.rst_en),
        .len_code(mode_q.len_code), .pulse(wdt_rst)
    );

    assign wdt_irq = sts_q && mode_q.irq_en;

    always_comb begin
        unique case (reg_sel_e'(addr[3:2]))
            REG_MODE:   rd_data = {26'd0, mode_q.len_code, 1'b0,
                                   mode_q.irq_en, mode_q.rst_en, mode_q.en};
            REG_CTRL:   rd_data = {18'd0, ctrl_q.reload, ctrl_q.div_sel};
            REG_STATUS: rd_data = {31'd0, sts_q};
            default:    rd_data = 32'd0;
        endcase
    end

endmodule

// File: rtl/wdg_checker.sv
module wdg_checker #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned CNT_W  = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wr_data,
    input logic [4:0]        mode_bits,
    input logic [13:0]       ctrl_bits,
    input logic              sts_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              reload_evt,
    input logic              expire,
    input logic              wdt_irq,
    input logic              wdt_rst
);

    logic [5:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)          run_q <= '0;
        else if (wdt_rst) run_q <= run_q + 1'b1;
        else              run_q <= '0;
    end

    AST_MODE_KEY: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr[3:2] == 2'd0 && wr_data[23:12] != 12'hABC) |=> $stable(mode_bits)); // R2

    AST_CTRL_KEY: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr[3:2] == 2'd1 && wr_data[23:12] != 12'h920) |=> $stable(ctrl_bits)); // R3

    AST_STS_STICKY: assert property (@(posedge clk) disable iff (rst)
        (sts_q && !reload_evt) |=> sts_q); // R6

    AST_PULSE_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $rose(wdt_rst) |-> $past(expire)); // R7

    AST_PULSE_MAX: assert property (@(posedge clk) disable iff (rst)
        run_q <= 6'd16); // R7

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        wdt_irq |-> sts_q); // R8

    AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (!mode_bits[0] && !reload_evt) |=> $stable(cnt_q)); // R9

    AST_RELOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        reload_evt |=> !sts_q); // R5

endmodule

bind wdg_timer wdg_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .mode_bits(mode_q), .ctrl_bits(ctrl_q), .sts_q(sts_q), .cnt_q(cnt_q),
    .reload_evt(reload_evt), .expire(expire), .wdt_irq(wdt_irq), .wdt_rst(wdt_rst)
);

// File: tb/wdg_timer_bench.sv
module wdg_timer_bench;

    localparam int SHIFT = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        wdt_irq;
    logic        wdt_rst;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    wdg_timer #(.ADDR_W(4), .FIELD_W(12), .CNT_SHIFT(SHIFT)) u_wdg_timer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .wdt_irq(wdt_irq), .wdt_rst(wdt_rst)
    );

    function automatic int interval(input int field, input int sel);
        return field * (1 << SHIFT) * (8 << (3 * sel));
    endfunction

    function automatic logic [31:0] mode_word(input logic [31:0] d);
        return d & 32'h37;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_timeout(input string req, input int t);
        logic [31:0] v;
        cyc(t - 1);
        rd(4'hC, v);
        chk(req, v, 32'd0);
        cyc(1);
        rd(4'hC, v);
        chk(req, v, 32'd1);
    endtask

    task automatic expect_pulse(input int len);
        chk("R7 pulse start", {31'd0, wdt_rst}, 32'd1);
        cyc(len - 1);
        chk("R7 pulse last", {31'd0, wdt_rst}, 32'd1);
        cyc(1);
        chk("R7 pulse end", {31'd0, wdt_rst}, 32'd0);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] mode_exp;
        logic [31:0] ctrl_exp;
        logic [31:0] d;
        void'($urandom(32'd1234));

        cyc(3);
        rst = 1'b0;
        cyc(1);
        rd(4'h0, v); chk("R1 mode", v, 32'h0);
        rd(4'h4, v); chk("R1 ctrl", v, 32'h3FFC);
        rd(4'hC, v); chk("R1 status", v, 32'h0);
        chk("R1 outs", {30'd0, wdt_irq, wdt_rst}, 32'd0);

        mode_exp = 32'h0;
        ctrl_exp = 32'h3FFC;
        for (int i = 0; i < 12; i++) begin
            d = $urandom() & ~32'h1;
            if (i % 2 == 0) begin
                if (d[23:12] == 12'hABC) d[12] = ~d[12];
            end else begin
                d[23:12] = 12'hABC;
                mode_exp = mode_word(d);
            end
            wr(4'h0, d);
            rd(4'h0, v); chk("R2 mode key", v, mode_exp);
        end
        for (int i = 0; i < 12; i++) begin
            d = $urandom();
            if (i % 2 == 0) begin
                if (d[23:12] == 12'h920) d[13] = ~d[13];
            end else begin
                d[23:12] = 12'h920;
                ctrl_exp = d & 32'h3FFF;
            end
            wr(4'h4, d);
            rd(4'h4, v); chk("R3 ctrl key", v, ctrl_exp);
        end

        // R4 R6 R7 R8: div 8, field 1, pulse code 3
        wr(4'h0, 32'h00ABC000);
        wr(4'h4, 32'h00920000 | (1 << 2) | 0);
        wr(4'h0, 32'h00ABC037);
        expect_timeout("R4 sel0", interval(1, 0));
        chk("R8 irq on", {31'd0, wdt_irq}, 32'd1);
        expect_pulse(16);
        cyc(300);
        rd(4'hC, v); chk("R6 sticky", v, 32'd1);
        chk("R7 once", {31'd0, wdt_rst}, 32'd0);

        // R5: wrong service words
        for (int i = 0; i < 6; i++) begin
            d = $urandom();
            if (d == 32'h1999) d = 32'h1998;
            wr(4'h8, d);
        end
        rd(4'hC, v); chk("R5 bad service", v, 32'd1);
        wr(4'h8, 32'h00001999);
        rd(4'hC, v); chk("R5 service clears", v, 32'd0);
        chk("R8 irq off", {31'd0, wdt_irq}, 32'd0);

        // R5: bad words mid-interval do not shift timing; good one does
        wr(4'h4, 32'h00920000 | (2 << 2) | 0);
        wr(4'h8, 32'h00001999);
        cyc(99);
        wr(4'h8, 32'h00001998);
        wr(4'h8, 32'h00001999);
        expect_timeout("R5 restart timing", interval(2, 0));

        // R7: code 0 pulse length 2, irq disabled
        wr(4'h0, 32'h00ABC003);
        wr(4'h4, 32'h00920000 | (1 << 2) | 0);
        wr(4'h8, 32'h00001999);
        expect_timeout("R4 sel0 again", interval(1, 0));
        chk("R8 irq disabled", {31'd0, wdt_irq}, 32'd0);
        expect_pulse(2);

        // R7: reset output disabled
        wr(4'h0, 32'h00ABC005);
        wr(4'h8, 32'h00001999);
        expect_timeout("R6 no rst", interval(1, 0));
        chk("R7 no pulse", {31'd0, wdt_rst}, 32'd0);
        chk("R8 irq enabled", {31'd0, wdt_irq}, 32'd1);

        // R9: disable freezes counting
        wr(4'h8, 32'h00001999);
        cyc(50);
        wr(4'h0, 32'h00ABC004);
        cyc(3 * interval(1, 0));
        rd(4'hC, v); chk("R9 disabled", v, 32'd0);

        // R10: enabling reloads
        wr(4'h0, 32'h00ABC005);
        expect_timeout("R10 enable reload", interval(1, 0));
        wr(4'h0, 32'h00ABC004);
        wr(4'h0, 32'h00ABC005);
        rd(4'hC, v); chk("R10 clears status", v, 32'd0);

        // R4: other dividers
        wr(4'h4, 32'h00920000 | (1 << 2) | 1);
        wr(4'h8, 32'h00001999);
        expect_timeout("R4 sel1", interval(1, 1));
        wr(4'h4, 32'h00920000 | (1 << 2) | 2);
        wr(4'h8, 32'h00001999);
        expect_timeout("R4 sel2", interval(1, 2));
        wr(4'h4, 32'h00920000 | (1 << 2) | 3);
        wr(4'h8, 32'h00001999);
        expect_timeout("R4 sel3", interval(1, 3));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule